// File: doc/BRIEF.md
# Crosswise Halving Add/Subtract Unit

This block is a small SIMD datapath stage. It takes two 32-bit operands and splits each one into two unsigned 16-bit lanes. It pairs the lanes crosswise: the upper lane of operand A works with the lower lane of operand B, and the lower lane of A works with the upper lane of B. One lane result is a sum and the other is a difference. Every lane result is formed one bit wider than the lane and then halved, so no carry or borrow is lost.

A one-bit select picks which lane adds and which lane subtracts. The result is captured in a register one cycle after a valid input. A result-valid output marks the cycle in which the register holds a fresh value. The unit has no flags of its own and drives no flag state, so the surrounding pipeline can issue it without any side effects.

Top module: `hx_xhalve_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `res` to zero and `res_valid` to 0.
- R2: Out of reset, `res_valid` equals the value `in_valid` had at the previous clock edge.
- R3: With `sub_first`=0, `res[31:16]` after a valid input is bits 16:1 of the 17-bit sum `opa[31:16] + opb[15:0]`.
- R4: With `sub_first`=0, `res[15:0]` after a valid input is bits 16:1 of the 17-bit two's-complement difference `opa[15:0] - opb[31:16]`.
- R5: With `sub_first`=1, `res[31:16]` after a valid input is bits 16:1 of the 17-bit two's-complement difference `opa[31:16] - opb[15:0]`.
- R6: With `sub_first`=1, `res[15:0]` after a valid input is bits 16:1 of the 17-bit sum `opa[15:0] + opb[31:16]`.
- R7: The carry out of a lane sum is kept as the top bit of that halved lane: 0xFFFF+0xFFFF gives 0xFFFF, and 0x8000+0x8000 gives 0x8000.
- R8: A difference with a negative result has its top bit set. For example, 0x0000 − 0x0001 gives 0xFFFF in whichever lane subtracts.
- R9: The lanes are independent: changing only the operand halves feeding one lane leaves the other lane's result unchanged.
- R10: When `in_valid` is 0 at a clock edge (out of reset), `res` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid and the result is captured at this edge |
| sub_first | input | 1 | Variant select: 0 = upper lane adds and lower lane subtracts; 1 = upper lane subtracts and lower lane adds |
| opa | input | 32 | First operand, two unsigned 16-bit lanes |
| opb | input | 32 | Second operand, two unsigned 16-bit lanes, used crosswise |
| res | output | 32 | Registered result, two halved 16-bit lanes |
| res_valid | output | 1 | High in the cycle after a valid input |

## Verification
The main function is swept over every combination of the four operand halves drawn from the set 0x0000, 0x0001, 0x7FFF, 0x8000, 0xFFFE and 0xFFFF, under both variant selects.

- Sums that carry out show whether the carry is kept or dropped.
- Differences that cross zero show whether the borrow reaches the top bit of the lane.
- Odd and even neighbours such as 0x7FFF and 0x8000 check that the halving uses the right bit positions.

Pseudo-random operand pairs then cover the general case. Directed pairs that change only one lane's inputs check that the crosswise pairing uses the correct halves and that nothing leaks between lanes.

// File: rtl/hx_pkg.sv
package hx_pkg;
  // Which lane adds and which subtracts.
  typedef enum logic {
    HX_ADD_HI = 1'b0,  // upper lane adds, lower lane subtracts
    HX_SUB_HI = 1'b1   // upper lane subtracts, lower lane adds
  } hx_variant_e;

  localparam int HX_LANES = 2;
endpackage

// File: rtl/hx_halve_lane.sv
module hx_halve_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         do_sub,
  output logic [W-1:0] q,
  output logic         wide_msb
);
  localparam int WX = W + 1;

  // The sum is widened by one bit so that the carry survives the halving.
  function automatic logic [WX-1:0] widen_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // The difference is formed as a WX-bit two's-complement value; its sign ends up in the top bit.
  function automatic logic [WX-1:0] widen_diff(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  logic [WX-1:0] wide;

  always_comb begin
    if (do_sub) wide = widen_diff(x, y);
    else        wide = widen_sum(x, y);
  end

  // Halving: drop the least significant bit of the widened value.
  assign q        = wide[WX-1:1];
  assign wide_msb = wide[WX-1];
endmodule

// File: rtl/hx_cross_route.sv
module hx_cross_route
  import hx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2*W-1:0] a,
  input  logic [2*W-1:0] b,
  input  hx_variant_e    variant,
  output logic [2*W-1:0] q,
  output logic [1:0]     lane_msb
);
  // Lane k of operand a is paired with the opposite lane of operand b.
  for (genvar k = 0; k < HX_LANES; k++) begin : g_lane
    localparam int PARTNER = HX_LANES - 1 - k;
    logic sub_here;

    if (k == HX_LANES - 1) begin : g_upper
      assign sub_here = (variant == HX_SUB_HI);
    end else begin : g_lower
      assign sub_here = (variant == HX_ADD_HI);
    end

    hx_halve_lane #(.W(W)) u_lane (
      .x        (a[k*W +: W]),
      .y        (b[PARTNER*W +: W]),
      .do_sub   (sub_here),
      .q        (q[k*W +: W]),
      .wide_msb (lane_msb[k])
    );
  end
endmodule

// File: rtl/hx_xhalve_top.sv
module hx_xhalve_top
  import hx_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                sub_first,
  input  logic [2*LANE_W-1:0] opa,
  input  logic [2*LANE_W-1:0] opb,
  output logic [2*LANE_W-1:0] res,
  output logic                res_valid
);
  localparam int DATA_W = 2 * LANE_W;

  hx_variant_e       variant;
  logic [DATA_W-1:0] lane_res;
  logic [1:0]        lane_msb;  // widened top bit of each lane, named for the checker

  assign variant = hx_variant_e'(sub_first);

  hx_cross_route #(.W(LANE_W)) u_route (
    .a        (opa),
    .b        (opb),
    .variant  (variant),
    .q        (lane_res),
    .lane_msb (lane_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= lane_res;
    end
  end
endmodule

// File: rtl/hx_xhalve_chk.sv
module hx_xhalve_chk #(
  parameter int LANE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                sub_first,
  input logic [2*LANE_W-1:0] opa,
  input logic [2*LANE_W-1:0] opb,
  input logic [2*LANE_W-1:0] res,
  input logic                res_valid,
  input logic [1:0]          lane_msb
);
  localparam int DATA_W = 2 * LANE_W;

  logic [LANE_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [LANE_W:0]   hi_sum, lo_diff;

  assign a_hi    = opa[DATA_W-1:LANE_W];
  assign a_lo    = opa[LANE_W-1:0];
  assign b_hi    = opb[DATA_W-1:LANE_W];
  assign b_lo    = opb[LANE_W-1:0];
  assign hi_sum  = {1'b0, a_hi} + {1'b0, b_lo};
  assign lo_diff = {1'b0, a_lo} - {1'b0, b_hi};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (res == '0 && !res_valid));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res));

  // R3
  hi_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_first) |=> res[DATA_W-1:LANE_W] == $past(hi_sum[LANE_W:1]));

  // R4
  lo_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_first) |=> res[LANE_W-1:0] == $past(lo_diff[LANE_W:1]));

  // R7: a carry happens exactly when a exceeds the complement of b
  carry_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_first && (a_hi > ~b_lo)) |=> res[DATA_W-1]);

  // R8
  neg_top_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_first && (a_lo < b_hi)) |=> res[LANE_W-1]);

  // R8: a borrowing lane sets its widened top bit
  borrow_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_first && (a_hi < b_lo)) |-> lane_msb[1]);
endmodule

bind hx_xhalve_top hx_xhalve_chk #(.LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .sub_first (sub_first),
  .opa       (opa),
  .opb       (opb),
  .res       (res),
  .res_valid (res_valid),
  .lane_msb  (lane_msb)
);

// File: tb/hx_xhalve_top_tb_top.sv
module hx_xhalve_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;
  localparam int WRAP = 1 << (LW + 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        sub_first = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] res;
  logic        res_valid;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #(CLK_PERIOD/2) clk = ~clk;

  hx_xhalve_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sub_first(sub_first),
    .opa(opa), .opb(opb), .res(res), .res_valid(res_valid)
  );

  // Reference arithmetic: integer halving of a sum, and a difference taken modulo 2^17 before halving.
  function automatic int ref_add(input int a, input int b);
    return (a + b) / 2;
  endfunction

  function automatic int ref_sub(input int a, input int b);
    int d;
    d = a - b;
    if (d < 0) d = d + WRAP;
    return d / 2;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive one valid operation, then sample in the next low phase, one register stage later.
  task automatic apply(input logic sel, input logic [31:0] a, input logic [31:0] b);
    int ah, al, bh, bl;
    @(negedge clk);
    sub_first = sel; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    ah = int'(a[31:16]); al = int'(a[15:0]);
    bh = int'(b[31:16]); bl = int'(b[15:0]);
    if (!sel) begin
      check("R3 upper add", {16'h0, res[31:16]}, ref_add(ah, bl));
      check("R4 lower sub", {16'h0, res[15:0]},  ref_sub(al, bh));
    end else begin
      check("R5 upper sub", {16'h0, res[31:16]}, ref_sub(ah, bl));
      check("R6 lower add", {16'h0, res[15:0]},  ref_add(al, bh));
    end
  endtask

  initial begin
    logic [15:0] corner [6];
    logic [31:0] keep;
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
    corner[3] = 16'h8000; corner[4] = 16'hFFFE; corner[5] = 16'hFFFF;

    repeat (3) @(negedge clk);
    // R1: state after reset
    check("R1 reset res", res, 32'h0);
    check("R1 reset valid", {31'h0, res_valid}, 32'h0);
    rst = 1'b0;

    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 6; k++)
            for (int m = 0; m < 6; m++)
              apply(s[0], {corner[i], corner[j]}, {corner[k], corner[m]});

    // R2: valid follows a valid input
    check("R2 valid high", {31'h0, res_valid}, 32'h1);

    for (int n = 0; n < 1000; n++) begin
      logic [31:0] ra;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      ra = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      apply(ra[7], ra, lfsr);
    end

    // R7: carry out kept
    apply(1'b0, 32'hFFFF_0000, 32'h0000_FFFF);
    check("R7 carry ffff", {16'h0, res[31:16]}, 32'hFFFF);
    apply(1'b0, 32'h8000_0000, 32'h0000_8000);
    check("R7 carry 8000", {16'h0, res[31:16]}, 32'h8000);
    apply(1'b1, 32'h0000_FFFF, 32'hFFFF_0000);
    check("R7 carry lower", {16'h0, res[15:0]}, 32'hFFFF);

    // R8: negative difference
    apply(1'b0, 32'h0000_0000, 32'h0001_0000);
    check("R8 lower 0-1", {16'h0, res[15:0]}, 32'hFFFF);
    apply(1'b1, 32'h0000_0000, 32'h0000_0001);
    check("R8 upper 0-1", {16'h0, res[31:16]}, 32'hFFFF);

    // R9: only the lower lane's inputs change; the upper lane must not move
    apply(1'b0, 32'hABCD_0000, 32'h0000_1111);
    keep = res;
    apply(1'b0, 32'hABCD_FFFF, 32'hFFFF_1111);
    check("R9 upper isolated", {16'h0, res[31:16]}, {16'h0, keep[31:16]});
    apply(1'b1, 32'h0000_4321, 32'h2222_0000);
    keep = res;
    apply(1'b1, 32'hFFFF_4321, 32'h2222_FFFF);
    check("R9 lower isolated", {16'h0, res[15:0]}, {16'h0, keep[15:0]});

    // R10 and R2: idle input holds the result and drops valid
    keep = res;
    @(negedge clk);
    in_valid = 1'b0; opa = 32'h1357_9BDF; opb = 32'h2468_ACE0; sub_first = 1'b0;
    @(negedge clk);
    check("R2 valid low", {31'h0, res_valid}, 32'h0);
    @(negedge clk);
    check("R10 hold", res, keep);

    // R1: reset during operation
    apply(1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 mid reset res", res, 32'h0);
    check("R1 mid reset valid", {31'h0, res_valid}, 32'h0);
    rst = 1'b0;
    in_valid = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule